// File: doc/BRIEF.md
# Iterative Modular Inverse Unit

This unit finds the greatest common divisor of a 32-bit operand and a 32-bit modulus. It also finds the multiplicative inverse of the operand modulo that modulus. It uses the extended Euclidean recurrence and performs one quotient step on every clock cycle. The remainder pair and the Bezout coefficient pair live in registers. One combinational divider and remainder unit advances them once per cycle until the remainder reaches zero.

A caller places the operand and the modulus on the inputs and pulses `start_i` for one cycle. `done_o` then rises and stays high. While it is high, the unit shows the GCD, the inverse in the range [0, modulus), and a failure flag. The failure flag is set when no inverse exists. A zero modulus never reaches the divider: the unit finishes at once and reports a failure. A new start pulse while the unit is finished launches the next operation. A start pulse while the unit is computing has no effect.

Top module: `xgcd_inv`

## Requirements
- R1: While `rst_ni` is low and after it is released, `done_o`, `inv_fail_o`, `gcd_o` and `inverse_o` are all zero until an operation completes.
- R2: A start with a nonzero modulus runs one division step per clock. Let N be the number of divisions until the remainder becomes zero. `done_o` then rises exactly N rising edges after the edge that sampled `start_i`.
- R3: When finished, `gcd_o` equals gcd(number, modulus).
- R4: When finished with `inv_fail_o` low, `inverse_o` is less than the modulus and (number × inverse_o) mod modulus equals 1. For modulus 1 this value is 0.
- R5: When finished, `inv_fail_o` is 1 exactly when the GCD differs from 1 or the modulus is 0. `inverse_o` is 0 whenever `inv_fail_o` is 1.
- R6: A zero modulus completes on the same edge that sampled the start. It gives `gcd_o` = number and `inv_fail_o` = 1, and the divider never sees a zero divisor.
- R7: A start pulse while the unit is computing is ignored. The running operation finishes with its own results and its own latency.
- R8: While the unit is finished and `start_i` is low, all outputs hold their values. A start while the unit is finished begins a new operation.
- R9: While the unit is idle or computing, `gcd_o`, `inverse_o` and `inv_fail_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| number_i | input | 32 | Value to invert |
| modulus_i | input | 32 | Modulus |
| gcd_o | output | 32 | GCD of the operands, valid while done |
| inverse_o | output | 32 | Inverse modulo the modulus, valid while done |
| inv_fail_o | output | 1 | No inverse exists, valid while done |
| done_o | output | 1 | Result available |

## Verification
The edge that samples `start_i` loads the operands. Every later edge performs one division step, and the edge that yields a zero remainder also sets `done_o`. The latency is therefore the exact step count N, and for a zero modulus it is zero. The bench drives on falling edges and also samples on falling edges. It counts the edges from the start edge until `done_o` appears, and compares that count with N from its own Euclid loop. It checks the results only in the cycle where `done_o` is first seen, and again after several idle cycles to confirm they hold.

// File: rtl/xgcd_pkg.sv
package xgcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b001,
    ST_RUN  = 3'b010,
    ST_DONE = 3'b100
  } state_e;
endpackage

// File: rtl/xgcd_ctrl.sv
module xgcd_ctrl
  import xgcd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   mod_zero_i,
  input  logic   last_i,
  output state_e state_o,
  output logic   load_o,
  output logic   step_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = mod_zero_i ? ST_DONE : ST_RUN;
      ST_RUN:           if (last_i)  state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign load_o  = start_i && (state_q != ST_RUN);
  assign step_o  = (state_q == ST_RUN);

  assert_state_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);
endmodule

// File: rtl/xgcd_step.sv
module xgcd_step #(
  parameter int W  = 32,
  parameter int CW = W + 2
) (
  input  logic                 [W-1:0]  a_i,
  input  logic                 [W-1:0]  b_i,
  input  logic signed          [CW-1:0] p_i,
  input  logic signed          [CW-1:0] r_i,
  output logic                 [W-1:0]  a_o,
  output logic                 [W-1:0]  b_o,
  output logic signed          [CW-1:0] p_o,
  output logic signed          [CW-1:0] r_o,
  output logic                          last_o
);
  localparam int PAD = CW - W;

  logic [W-1:0]         div;
  logic [W-1:0]         quo;
  logic [W-1:0]         rem;
  logic signed [CW-1:0] prod;

  // divisor is never zero in use; guard keeps the operator defined
  assign div  = (b_i == '0) ? W'(1) : b_i;
  assign quo  = a_i / div;
  assign rem  = a_i % div;
  // true |q*r| fits CW bits, so low CW bits are exact
  assign prod = $signed({{PAD{1'b0}}, quo}) * r_i;

  assign a_o    = b_i;
  assign b_o    = rem;
  assign p_o    = r_i;
  assign r_o    = p_i - prod;
  assign last_o = (rem == '0);
endmodule

// File: rtl/xgcd_fix.sv
module xgcd_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W:0]   p_i,   // sign bit plus low W bits of the coefficient
  input  logic [W-1:0] m_i,
  output logic [W-1:0] gcd_o,
  output logic [W-1:0] inv_o,
  output logic         fail_o
);
  logic [W-1:0] adj;

  // negative coefficient: add modulus, result lands in [0, m)
  assign adj    = p_i[W] ? (p_i[W-1:0] + m_i) : p_i[W-1:0];
  assign fail_o = (a_i != W'(1)) || (m_i == '0);
  assign gcd_o  = a_i;
  assign inv_o  = fail_o ? '0 : adj;
endmodule

// File: rtl/xgcd_inv.sv
module xgcd_inv
  import xgcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] number_i,
  input  logic [W-1:0] modulus_i,
  output logic [W-1:0] gcd_o,
  output logic [W-1:0] inverse_o,
  output logic         inv_fail_o,
  output logic         done_o
);
  localparam int CW = W + 2;

  state_e state;
  logic   load, step, last;

  logic [W-1:0]         a_q, b_q, m_q;
  logic signed [CW-1:0] p_q, r_q;
  logic [W-1:0]         a_nx, b_nx;
  logic signed [CW-1:0] p_nx, r_nx;
  logic [W-1:0]         fx_gcd, fx_inv;
  logic                 fx_fail;

  xgcd_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mod_zero_i (modulus_i == '0),
    .last_i     (last),
    .state_o    (state),
    .load_o     (load),
    .step_o     (step)
  );

  xgcd_step #(.W(W), .CW(CW)) u_step (
    .a_i    (a_q),
    .b_i    (b_q),
    .p_i    (p_q),
    .r_i    (r_q),
    .a_o    (a_nx),
    .b_o    (b_nx),
    .p_o    (p_nx),
    .r_o    (r_nx),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      m_q <= '0;
      p_q <= '0;
      r_q <= '0;
    end else if (load) begin
      a_q <= number_i;
      b_q <= modulus_i;
      m_q <= modulus_i;
      p_q <= CW'(1);
      r_q <= '0;
    end else if (step) begin
      a_q <= a_nx;
      b_q <= b_nx;
      p_q <= p_nx;
      r_q <= r_nx;
    end
  end

  xgcd_fix #(.W(W)) u_fix (
    .a_i    (a_q),
    .p_i    ({p_q[CW-1], p_q[W-1:0]}),
    .m_i    (m_q),
    .gcd_o  (fx_gcd),
    .inv_o  (fx_inv),
    .fail_o (fx_fail)
  );

  assign done_o     = (state == ST_DONE);
  assign gcd_o      = done_o ? fx_gcd : '0;
  assign inverse_o  = done_o ? fx_inv : '0;
  assign inv_fail_o = done_o && fx_fail;

  assert_no_div_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> (b_q != '0));
  assert_fail_clears_inv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_fail_o |-> (inverse_o == '0));
  assert_inv_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !inv_fail_o) |-> (inverse_o < m_q));
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && start_i) |=> $stable(m_q));
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(gcd_o) && $stable(inverse_o) && $stable(inv_fail_o)));
  assert_quiet_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (gcd_o == '0 && inverse_o == '0 && !inv_fail_o));
endmodule

// File: tb/xgcd_inv_bench.sv
module xgcd_inv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] num = '0;
  logic [31:0] mdl = '0;
  logic [31:0] gcd_o, inv_o;
  logic        fail_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xgcd_inv u_xgcd_inv (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .number_i   (num),
    .modulus_i  (mdl),
    .gcd_o      (gcd_o),
    .inverse_o  (inv_o),
    .inv_fail_o (fail_o),
    .done_o     (done_o)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_euclid(input longint unsigned n, input longint unsigned m,
                            output longint unsigned g, output int steps);
    longint unsigned a = n, b = m, c;
    steps = 0;
    while (b != 0) begin
      c = a % b; a = b; b = c; steps++;
    end
    g = a;
  endtask

  // drive start, then count edges until done; leaves sampling on a negedge
  task automatic run_op(input logic [31:0] n, input logic [31:0] m, output int lat);
    @(negedge clk); start = 1'b1; num = n; mdl = m;
    @(negedge clk); start = 1'b0; lat = 0;
    while (!done_o && lat < 500) begin @(negedge clk); lat++; end
  endtask

  task automatic check_result(input string tag, input logic [31:0] n, input logic [31:0] m, input int lat);
    longint unsigned g; int s;
    ref_euclid(n, m, g, s);
    check({tag, " R2 latency"}, lat, s);
    check({tag, " R3 gcd"}, gcd_o, g);
    if (m == 0 || g != 1) begin
      check({tag, " R5 fail flag"}, fail_o, 1);
      check({tag, " R5 inverse zero"}, inv_o, 0);
    end else begin
      check({tag, " R5 fail flag"}, fail_o, 0);
      check({tag, " R4 range"}, (inv_o < m) ? 1 : 0, 1);
      check({tag, " R4 product"}, (longint'(n) * longint'(inv_o)) % longint'(m), (m == 1) ? 0 : 1);
    end
  endtask

  task automatic t_reset;
    check("R1 done", done_o, 0);
    check("R1 gcd", gcd_o, 0);
    check("R1 inverse", inv_o, 0);
    check("R1 fail", fail_o, 0);
  endtask

  task automatic t_op(input string tag, input logic [31:0] n, input logic [31:0] m);
    int lat;
    run_op(n, m, lat);
    check_result(tag, n, m, lat);
  endtask

  task automatic t_small_known;
    int lat;
    run_op(32'd3, 32'd7, lat);
    check("R2 3 mod 7 latency", lat, 3);
    check("R4 3 mod 7 inverse", inv_o, 5);
  endtask

  task automatic t_zero_mod;
    int lat;
    run_op(32'd5, 32'd0, lat);
    check("R6 zero modulus latency", lat, 0);
    check("R6 zero modulus gcd", gcd_o, 5);
    check("R6 zero modulus fail", fail_o, 1);
    check("R6 zero modulus inverse", inv_o, 0);
  endtask

  task automatic t_busy_quiet;
    int lat;
    @(negedge clk); start = 1'b1; num = 32'd1836311903; mdl = 32'd2971215073;
    @(negedge clk); start = 1'b0;
    // first cycle of computation: R9 outputs read zero
    check("R9 busy done", done_o, 0);
    check("R9 busy gcd", gcd_o, 0);
    check("R9 busy inverse", inv_o, 0);
    check("R9 busy fail", fail_o, 0);
    lat = 0;
    while (!done_o && lat < 500) begin @(negedge clk); lat++; end
    check_result("fib", 32'd1836311903, 32'd2971215073, lat);
  endtask

  task automatic t_ignore_start;
    int lat;
    @(negedge clk); start = 1'b1; num = 32'd1836311903; mdl = 32'd2971215073;
    @(negedge clk); start = 1'b0; lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    start = 1'b1; num = 32'd6; mdl = 32'd9;   // R7 pulse mid-run
    @(negedge clk); lat++; start = 1'b0;
    while (!done_o && lat < 500) begin @(negedge clk); lat++; end
    check_result("R7 ignored start", 32'd1836311903, 32'd2971215073, lat);
  endtask

  task automatic t_hold;
    logic [31:0] g0, i0; logic f0;
    g0 = gcd_o; i0 = inv_o; f0 = fail_o;
    repeat (6) @(negedge clk);
    check("R8 hold done", done_o, 1);
    check("R8 hold gcd", gcd_o, g0);
    check("R8 hold inverse", inv_o, i0);
    check("R8 hold fail", fail_o, f0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_known();
    t_hold();
    t_op("R8 restart from done", 32'd100, 32'd7);
    t_op("prime modulus", 32'd123456789, 32'd4294967291);
    t_op("common factor", 32'd6, 32'd9);
    t_op("modulus one", 32'd12345, 32'd1);
    t_op("number zero", 32'd0, 32'd7);
    t_op("max modulus", 32'd2, 32'hFFFF_FFFF);
    check("R4 max modulus inverse", inv_o, 32'h8000_0000);
    t_zero_mod();
    t_op("R6 zero modulus number one", 32'd1, 32'd0);
    t_busy_quiet();
    t_ignore_start();
    t_hold();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule